// File: doc/BRIEF.md
# Width-Aware I/O Port Decoder

This block is the slave side of a small I/O port window that looks like a disk controller's command block. It sits on a plain I/O bus with a 16-bit port address, a read strobe, a write strobe, a width flag and a 16-bit data path. The block picks the target register from the port address and the access width together. A word access and a byte access to addresses that overlap can therefore reach different storage. A word access at the window base moves one whole word through an internal data FIFO. A byte access one port above the base reaches an 8-bit error register that has nothing to do with the upper half of that word.

A byte access two ports above the base reaches an 8-bit count register. A word access that starts one port above the base treats the error and count registers as a pair. Every other combination of address and width returns all ones and changes nothing. Byte reads return their value on the low lane, with the high lane driven to all ones.

Top module: `io_width_decoder`

## Requirements
- R1: After reset, rdata is 0xFFFF, the error register and the count register read 0x00, and the data FIFO is empty.
- R2: A word write (wide=1) at the base port pushes wdata into the FIFO. A word read at the base port pops the oldest word. rdata shows the popped word on the clock after the read strobe, and words come out in the order they went in.
- R3: The FIFO holds 8 words. A word write at the base port while the FIFO is full is dropped and sets error bit 1 (overflow). The stored words are unchanged.
- R4: A data read at the base port (either width) while the FIFO is empty returns 0xFFFF and sets error bit 0 (underflow).
- R5: A byte read (wide=0) at the base port pops one whole FIFO word. It returns that word's low byte on rdata[7:0], with rdata[15:8]=0xFF.
- R6: A byte access at base+1 reads or writes the 8-bit error register. The register value is returned on rdata[7:0] with rdata[15:8]=0xFF. A write loads it at the write-strobe edge. Data FIFO traffic that does not fail leaves it unchanged.
- R7: A byte access at base+2 reads or writes an 8-bit count register in the same way. It is independent of the error register and of the FIFO.
- R8: A word access at base+1 treats a register pair as one word: the low byte is the error register and the high byte is the count register. A word write loads both.
- R9: Every other access reads 0xFFFF and writes nothing. This covers a byte write at the base, word accesses at base+2 and above, byte accesses at base+3 and above, and any address outside the 8-port window.
- R10: rdata holds its value on every clock without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Port address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| wdata | input | 16 | Write data; a byte write uses [7:0] |
| rdata | output | 16 | Registered read data |

## Verification
On every cycle, the assertions check the following:
- the underflow and overflow bits are set after a failing data access;
- an unmapped read returns all ones;
- rdata holds between reads;
- the FIFO is never pushed while full or popped while empty, and its count stays in range.

Some behaviours only the directed scenarios can show, because each one spans several accesses:
- FIFO ordering;
- a byte read at the base swallowing a whole word;
- the error register staying separate from the data word's upper half;
- the register-pair view at base+1;
- unmapped writes leaving every register and the FIFO untouched.

// File: rtl/iowd_pkg.sv
package iowd_pkg;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_DATA_W = 3'd1,
        SEL_DATA_B = 3'd2,
        SEL_ERR    = 3'd3,
        SEL_CNT    = 3'd4,
        SEL_PAIR   = 3'd5
    } port_sel_e;

    // Port offsets inside the window; the decode depends on them.
    localparam int unsigned OFF_DATA = 0;
    localparam int unsigned OFF_ERR  = 1;
    localparam int unsigned OFF_CNT  = 2;

    // Error register bit positions.
    localparam int unsigned ERR_UNDER_BIT = 0;
    localparam int unsigned ERR_OVER_BIT  = 1;

    localparam logic [15:0] ALL_ONES_W = 16'hFFFF;
    localparam logic [7:0]  ALL_ONES_B = 8'hFF;

endpackage

// File: rtl/iowd_port_decode.sv
module iowd_port_decode
    import iowd_pkg::*;
#(
    parameter logic [15:0] BASE    = 16'h01F0,
    parameter int unsigned WIN_LEN = 8
) (
    input  logic [15:0] addr,
    input  logic        wide,
    output port_sel_e   sel
);
    localparam int unsigned OFF_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [16:0] BASE17 = {1'b0, BASE};
    localparam logic [16:0] LEN17  = 17'(WIN_LEN);

    logic [16:0]      off17;
    logic             in_win;
    logic [OFF_W-1:0] off;

    always_comb begin
        off17  = {1'b0, addr} - BASE17;
        in_win = ({1'b0, addr} >= BASE17) && (off17 < LEN17);
        off    = off17[OFF_W-1:0];
        sel    = SEL_NONE;
        if (in_win) begin
            if (wide) begin
                if (off == OFF_W'(OFF_DATA))
                    sel = SEL_DATA_W;
                else if (off == OFF_W'(OFF_ERR))
                    sel = SEL_PAIR;
            end else begin
                if (off == OFF_W'(OFF_DATA))
                    sel = SEL_DATA_B;
                else if (off == OFF_W'(OFF_ERR))
                    sel = SEL_ERR;
                else if (off == OFF_W'(OFF_CNT))
                    sel = SEL_CNT;
            end
        end
    end

endmodule

// File: rtl/iowd_data_fifo.sv
module iowd_data_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1))
            return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push)
            st_d.wp = bump(st_q.wp);
        if (pop)
            st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push)
            mem_q[st_q.wp] <= din;
    end

    assign head  = mem_q[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/io_width_decoder.sv
module io_width_decoder
    import iowd_pkg::*;
#(
    parameter logic [15:0] BASE       = 16'h01F0,
    parameter int unsigned WIN_LEN    = 8,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic        wide,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    typedef struct packed {
        logic [7:0]  err;
        logic [7:0]  cnt;
        logic [15:0] rdat;
    } regs_t;

    regs_t      r_d, r_q;
    port_sel_e  sel;
    logic       fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [15:0] fifo_head;
    logic       data_rd;

    iowd_port_decode #(.BASE(BASE), .WIN_LEN(WIN_LEN)) u_dec (
        .addr (addr),
        .wide (wide),
        .sel  (sel)
    );

    iowd_data_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (wdata),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        data_rd   = rd && (sel == SEL_DATA_W || sel == SEL_DATA_B);
        fifo_pop  = data_rd && !fifo_empty;
        fifo_push = wr && (sel == SEL_DATA_W) && !fifo_full;

        r_d = r_q;

        // Writes to the register bytes land on the strobe edge.
        if (wr) begin
            case (sel)
                SEL_ERR:  r_d.err = wdata[7:0];
                SEL_CNT:  r_d.cnt = wdata[7:0];
                SEL_PAIR: begin
                    r_d.err = wdata[7:0];
                    r_d.cnt = wdata[15:8];
                end
                default: ;
            endcase
        end

        // Sticky error events after any software write.
        if (wr && sel == SEL_DATA_W && fifo_full)
            r_d.err[ERR_OVER_BIT] = 1'b1;
        if (data_rd && fifo_empty)
            r_d.err[ERR_UNDER_BIT] = 1'b1;

        if (rd) begin
            case (sel)
                SEL_DATA_W: r_d.rdat = fifo_empty ? ALL_ONES_W : fifo_head;
                SEL_DATA_B: r_d.rdat = {ALL_ONES_B,
                                        fifo_empty ? ALL_ONES_B : fifo_head[7:0]};
                SEL_ERR:    r_d.rdat = {ALL_ONES_B, r_q.err};
                SEL_CNT:    r_d.rdat = {ALL_ONES_B, r_q.cnt};
                SEL_PAIR:   r_d.rdat = {r_q.cnt, r_q.err};
                default:    r_d.rdat = ALL_ONES_W;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.err  <= '0;
            r_q.cnt  <= '0;
            r_q.rdat <= ALL_ONES_W;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdat;

    assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == SEL_DATA_W || sel == SEL_DATA_B) && fifo_empty)
        |=> (r_q.err[ERR_UNDER_BIT] && rdata[7:0] == 8'hFF));
    assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA_W && fifo_full) |=> r_q.err[ERR_OVER_BIT]);
    assert_unmapped_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> (rdata == 16'hFFFF));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wide) |=> (rdata[15:8] == 8'hFF));

endmodule

// File: tb/io_width_decoder_bench.sv
`timescale 1ns/1ps
module io_width_decoder_bench;
    localparam logic [15:0] BASE = 16'h01F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0, wide = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    io_width_decoder u_io_width_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wide(wide), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        addr = a; wide = w; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_port(input logic [15:0] a, input logic w, output logic [15:0] d);
        @(negedge clk);
        addr = a; wide = w; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic clear_err();
        wr_port(BASE + 16'd1, 1'b0, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rdata", rdata, 16'hFFFF);
        rd_port(BASE + 16'd1, 1'b0, v); check("R1 err", v, 16'hFF00);
        rd_port(BASE + 16'd2, 1'b0, v); check("R1 cnt", v, 16'hFF00);
        rd_port(BASE, 1'b1, v);         check("R1 fifo empty", v, 16'hFFFF);
        clear_err();
    endtask

    task automatic t_fifo_order();
        logic [15:0] v;
        wr_port(BASE, 1'b1, 16'h1234);
        wr_port(BASE, 1'b1, 16'hABCD);
        wr_port(BASE, 1'b1, 16'h00FF);
        rd_port(BASE, 1'b1, v); check("R2 first", v, 16'h1234);
        rd_port(BASE, 1'b1, v); check("R2 second", v, 16'hABCD);
        rd_port(BASE, 1'b1, v); check("R2 third", v, 16'h00FF);
        repeat (4) @(negedge clk);
        check("R10 hold", rdata, 16'h00FF);
        rd_port(BASE + 16'd1, 1'b0, v); check("R6 no err after good traffic", v, 16'hFF00);
    endtask

    task automatic t_underflow();
        logic [15:0] v;
        clear_err();
        rd_port(BASE, 1'b1, v);         check("R4 word empty", v, 16'hFFFF);
        rd_port(BASE + 16'd1, 1'b0, v); check("R4 underflow bit", v, 16'hFF01);
        clear_err();
        rd_port(BASE, 1'b0, v);         check("R4 byte empty", v, 16'hFFFF);
        rd_port(BASE + 16'd1, 1'b0, v); check("R4 byte underflow bit", v, 16'hFF01);
        clear_err();
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        clear_err();
        for (int i = 0; i < 9; i++) wr_port(BASE, 1'b1, 16'h5000 + 16'(i));
        rd_port(BASE + 16'd1, 1'b0, v); check("R3 overflow bit", v, 16'hFF02);
        for (int i = 0; i < 8; i++) begin
            rd_port(BASE, 1'b1, v);
            check("R3 kept word", v, 16'h5000 + 16'(i));
        end
        rd_port(BASE, 1'b1, v); check("R3 ninth dropped", v, 16'hFFFF);
        clear_err();
    endtask

    task automatic t_byte_pop();
        logic [15:0] v;
        wr_port(BASE, 1'b1, 16'hA1B2);
        wr_port(BASE, 1'b1, 16'hC3D4);
        rd_port(BASE, 1'b0, v); check("R5 low byte", v, 16'hFFB2);
        rd_port(BASE, 1'b1, v); check("R5 whole word consumed", v, 16'hC3D4);
    endtask

    task automatic t_err_indep();
        logic [15:0] v;
        wr_port(BASE + 16'd1, 1'b0, 16'h005A);
        wr_port(BASE, 1'b1, 16'h7788);
        rd_port(BASE, 1'b1, v);         check("R6 data word", v, 16'h7788);
        rd_port(BASE + 16'd1, 1'b0, v); check("R6 err independent", v, 16'hFF5A);
        clear_err();
    endtask

    task automatic t_cnt();
        logic [15:0] v;
        wr_port(BASE + 16'd2, 1'b0, 16'h003C);
        rd_port(BASE + 16'd2, 1'b0, v); check("R7 cnt", v, 16'hFF3C);
        rd_port(BASE + 16'd1, 1'b0, v); check("R7 err untouched", v, 16'hFF00);
        rd_port(BASE, 1'b1, v);         check("R7 fifo untouched", v, 16'hFFFF);
        clear_err();
    endtask

    task automatic t_pair();
        logic [15:0] v;
        wr_port(BASE + 16'd1, 1'b0, 16'h0011);
        wr_port(BASE + 16'd2, 1'b0, 16'h0022);
        rd_port(BASE + 16'd1, 1'b1, v); check("R8 pair read", v, 16'h2211);
        wr_port(BASE + 16'd1, 1'b1, 16'h9988);
        rd_port(BASE + 16'd1, 1'b0, v); check("R8 pair wrote err", v, 16'hFF88);
        rd_port(BASE + 16'd2, 1'b0, v); check("R8 pair wrote cnt", v, 16'hFF99);
        wr_port(BASE + 16'd1, 1'b1, 16'h4400);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr_port(BASE, 1'b0, 16'h0077);
        wr_port(BASE + 16'd2, 1'b1, 16'h1111);
        wr_port(BASE + 16'd3, 1'b0, 16'h0022);
        wr_port(BASE + 16'h0101, 1'b1, 16'h3333);
        rd_port(BASE + 16'd1, 1'b1, v); check("R9 regs untouched", v, 16'h4400);
        rd_port(BASE + 16'd2, 1'b1, v); check("R9 word at base+2", v, 16'hFFFF);
        rd_port(BASE + 16'd5, 1'b0, v); check("R9 byte at base+5", v, 16'hFFFF);
        rd_port(16'h0300, 1'b1, v);     check("R9 outside window", v, 16'hFFFF);
        rd_port(BASE - 16'd1, 1'b0, v); check("R9 below window", v, 16'hFFFF);
        rd_port(BASE, 1'b1, v);         check("R9 byte write pushed nothing", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fifo_order();
        t_underflow();
        t_overflow();
        t_byte_pop();
        t_err_indep();
        t_cnt();
        t_pair();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule